// File: doc/BRIEF.md
# Register-File Descriptor DMA Channel

This block moves single bytes between a serial peripheral and storage on behalf of that peripheral. It holds no address or count counters of its own. Each direction (receive and transmit) has a counter-pointer and an address-pointer register, and these locate the channel's descriptor inside a small general-purpose register file. For every request, the channel fetches the descriptor through the register-file port and checks the remaining count. It then moves one byte and writes the updated descriptor back. When the count runs out, it signals end of block.

Bit 0 of a counter pointer is the target-select bit. When it is 1, the data byte lives in the register file itself, at an 8-bit address. When it is 0, the data byte lives in a 16-bit memory space, which is reached through a valid/ready handshake. The descriptor base is always the pointer with bit 0 cleared. Any pointer whose pair would reach past register-file address DFh is rejected as a configuration error.

Top module: `rfdma_channel`

## Requirements
- R1: After reset, rx_ack, tx_ack, rx_eob, tx_eob, cfg_err, rf_en and mem_valid are all 0.
- R2: cfg_sel selects one of four pointer registers: 0 is the receive counter pointer, 1 the receive address pointer, 2 the transmit counter pointer and 3 the transmit address pointer. Bit 0 of a counter pointer selects the target (1 = register file, 0 = memory). The descriptor base is the pointer value with bit 0 cleared.
- R3: In register-file mode, the address byte is at the counter base and the count byte is at base+1. A receive writes rx_data to that address. A transmit reads that address and presents the byte on tx_data while tx_ack is high.
- R4: In register-file mode, the address pointer has no effect. An out-of-range value there raises no cfg_err and does not block the transfer.
- R5: In memory mode, the 16-bit count is at the counter base (high byte) and base+1 (low byte), and the 16-bit address is at the address base (high) and base+1 (low). The byte moves through mem_valid/mem_ready, with mem_we=1 for receive and mem_we=0 for transmit.
- R6: After each transfer, the stored address is written back as address+1 and the stored count as count-1. In memory mode, the carry or borrow propagates across both bytes.
- R7: A request whose counter pair, or (in memory mode) address pair, would extend past DFh gives a one-cycle cfg_err pulse. It causes no register-file access, no memory access and no acknowledge. A pair based at DEh is legal.
- R8: The end-of-block output for the direction rises in the same cycle as its acknowledge exactly when the written-back count is zero.
- R9: A request that finds a zero count gets no acknowledge, no memory access and no register-file write.
- R10: When receive and transmit requests are both pending, receive is served first.
- R11: Requests are served one at a time. mem_valid and mem_addr hold until mem_ready, and the register file is not accessed while mem_valid is high.
- R12: The receive and transmit directions use separate pointer registers and descriptors, so serving one leaves the other's descriptor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Pointer register write strobe |
| cfg_sel | input | 2 | Pointer register select |
| cfg_wdata | input | 8 | Pointer register write value |
| rx_req | input | 1 | Receive request, held until rx_ack |
| tx_req | input | 1 | Transmit request, held until tx_ack |
| rx_data | input | 8 | Received byte to store |
| rx_ack | output | 1 | Receive byte stored (one cycle) |
| tx_ack | output | 1 | Transmit byte fetched (one cycle) |
| tx_data | output | 8 | Fetched transmit byte, valid with tx_ack |
| rx_eob | output | 1 | Receive end of block |
| tx_eob | output | 1 | Transmit end of block |
| cfg_err | output | 1 | Pointer out of range on a request |
| rf_en | output | 1 | Register-file access enable |
| rf_we | output | 1 | Register-file write (else read) |
| rf_addr | output | 8 | Register-file address |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data, one cycle after the read |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory access completes |

## Verification
Some properties are checked on every cycle. Acknowledges are never given to both directions at once. End of block only ever accompanies an acknowledge. A configuration error never coincides with an acknowledge. A waiting memory request stays stable and never overlaps a register-file access.

Other behaviours can only be shown by the bench's scenarios, because they depend on descriptor contents:
- the byte layout of the descriptor pairs
- the carry and borrow in the write-back
- the zero-count refusal
- the range boundary at DEh/DFh
- the receive-first ordering
- the irrelevance of the address pointer in register-file mode

// File: rtl/rfdma_pkg.sv
package rfdma_pkg;
    localparam int RF_AW = 8;
    localparam int BW    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RWAIT,
        ST_CHK,
        ST_XFER,
        ST_XWAIT,
        ST_WB,
        ST_DONE
    } st_e;

    // descriptor byte slots held in the channel while a request is served
    localparam logic [1:0] SLOT_CNT_HI = 2'd0;
    localparam logic [1:0] SLOT_CNT_LO = 2'd1;
    localparam logic [1:0] SLOT_ADR_HI = 2'd2;
    localparam logic [1:0] SLOT_ADR_LO = 2'd3;
endpackage

// File: rtl/rfdma_cfg.sv
module rfdma_cfg #(
    parameter int AW   = 8,
    parameter int NDIR = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr,
    input  logic [$clog2(NDIR*2)-1:0]      sel,
    input  logic [AW-1:0]                  wdata,
    output logic [NDIR-1:0][AW-1:0]        cnt_ptr,
    output logic [NDIR-1:0][AW-1:0]        adr_ptr
);
    localparam int NREG = NDIR * 2;

    logic [NREG-1:0][AW-1:0] ptr_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ptr_q[g] <= '0;
            else if (wr && sel == g[$clog2(NREG)-1:0])
                ptr_q[g] <= wdata;
        end
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        assign cnt_ptr[d] = ptr_q[2*d];
        assign adr_ptr[d] = ptr_q[2*d+1];
    end
endmodule

// File: rtl/rfdma_range.sv
module rfdma_range #(
    parameter int          AW    = 8,
    parameter logic [AW:0] LIMIT = 9'h0DF
) (
    input  logic [AW-1:0] ptr,
    output logic          ok
);
    logic [AW:0] top_byte;

    // the odd partner of the pair is the highest byte the pair touches
    assign top_byte = {1'b0, ptr | {{(AW-1){1'b0}}, 1'b1}};
    assign ok       = (top_byte <= LIMIT);
endmodule

// File: rtl/rfdma_arb.sv
module rfdma_arb (
    input  logic idle,
    input  logic rx_req,
    input  logic tx_req,
    output logic gnt,
    output logic gnt_tx
);
    assign gnt    = idle && (rx_req || tx_req);
    assign gnt_tx = !rx_req && tx_req;
endmodule

// File: rtl/rfdma_channel.sv
module rfdma_channel
    import rfdma_pkg::*;
#(
    parameter int          AW    = rfdma_pkg::RF_AW,
    parameter int          DW    = rfdma_pkg::BW,
    parameter logic [AW:0] LIMIT = 9'h0DF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [1:0]      cfg_sel,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic            rx_req,
    input  logic            tx_req,
    input  logic [DW-1:0]   rx_data,
    output logic            rx_ack,
    output logic            tx_ack,
    output logic [DW-1:0]   tx_data,
    output logic            rx_eob,
    output logic            tx_eob,
    output logic            cfg_err,
    output logic            rf_en,
    output logic            rf_we,
    output logic [AW-1:0]   rf_addr,
    output logic [DW-1:0]   rf_wdata,
    input  logic [DW-1:0]   rf_rdata,
    output logic            mem_valid,
    output logic            mem_we,
    output logic [2*DW-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ready
);
    localparam int MAW = 2 * DW;

    typedef struct packed {
        st_e                  st;
        logic                 tx;
        logic                 rfm;
        logic [AW-1:0]        cbase;
        logic [AW-1:0]        abase;
        logic [1:0]           idx;
        logic                 rv;
        logic [1:0]           ridx;
        logic [3:0][DW-1:0]   b;
        logic [DW-1:0]        data;
        logic                 ack_rx;
        logic                 ack_tx;
        logic                 eob;
        logic                 err;
    } ctx_t;

    ctx_t q, d;

    logic [1:0][AW-1:0] cnt_ptr, adr_ptr;
    logic               gnt, gnt_tx, cnt_ok, adr_ok;
    logic [AW-1:0]      sel_cp, sel_ap;
    logic [MAW-1:0]     cnt16, adr16, new_cnt, new_adr;
    logic [1:0]         last_idx;

    rfdma_cfg #(.AW(AW), .NDIR(2)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
        .cnt_ptr(cnt_ptr), .adr_ptr(adr_ptr)
    );

    rfdma_arb u_arb (
        .idle(q.st == ST_IDLE), .rx_req(rx_req), .tx_req(tx_req),
        .gnt(gnt), .gnt_tx(gnt_tx)
    );

    assign sel_cp = gnt_tx ? cnt_ptr[1] : cnt_ptr[0];
    assign sel_ap = gnt_tx ? adr_ptr[1] : adr_ptr[0];

    rfdma_range #(.AW(AW), .LIMIT(LIMIT)) u_rng_cnt (.ptr(sel_cp), .ok(cnt_ok));
    rfdma_range #(.AW(AW), .LIMIT(LIMIT)) u_rng_adr (.ptr(sel_ap), .ok(adr_ok));

    assign cnt16    = {q.b[SLOT_CNT_HI], q.b[SLOT_CNT_LO]};
    assign adr16    = {q.b[SLOT_ADR_HI], q.b[SLOT_ADR_LO]};
    assign new_cnt  = cnt16 - 1'b1;
    assign new_adr  = adr16 + 1'b1;
    assign last_idx = q.rfm ? 2'd1 : 2'd3;

    // descriptor slot touched by step k of the read or write-back walk
    function automatic logic [1:0] slot_of(input logic rfm, input logic [1:0] k);
        if (rfm) return (k == 2'd0) ? SLOT_ADR_LO : SLOT_CNT_LO;
        return k;
    endfunction

    function automatic logic [AW-1:0] addr_of(input ctx_t c, input logic [1:0] k);
        logic [AW-1:0] base;
        base = (!c.rfm && k[1]) ? c.abase : c.cbase;
        return base | {{(AW-1){1'b0}}, k[0]};
    endfunction

    always_comb begin
        d         = q;
        d.ack_rx  = 1'b0;
        d.ack_tx  = 1'b0;
        d.eob     = 1'b0;
        d.err     = 1'b0;
        d.rv      = 1'b0;
        rf_en     = 1'b0;
        rf_we     = 1'b0;
        rf_addr   = addr_of(q, q.idx);
        rf_wdata  = '0;
        mem_valid = 1'b0;

        if (q.rv) d.b[slot_of(q.rfm, q.ridx)] = rf_rdata;

        case (q.st)
            ST_IDLE: begin
                if (gnt) begin
                    if (cnt_ok && (sel_cp[0] || adr_ok)) begin
                        d.st    = ST_RD;
                        d.idx   = 2'd0;
                        d.tx    = gnt_tx;
                        d.rfm   = sel_cp[0];
                        d.cbase = sel_cp & ~{{(AW-1){1'b0}}, 1'b1};
                        d.abase = sel_ap & ~{{(AW-1){1'b0}}, 1'b1};
                        d.b     = '0;
                        d.data  = rx_data;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            ST_RD: begin
                rf_en  = 1'b1;
                d.rv   = 1'b1;
                d.ridx = q.idx;
                if (q.idx == last_idx) d.st = ST_RWAIT;
                else                   d.idx = q.idx + 2'd1;
            end
            ST_RWAIT: d.st = ST_CHK;
            ST_CHK: d.st = (cnt16 == '0) ? ST_IDLE : ST_XFER;
            ST_XFER: begin
                if (q.rfm) begin
                    rf_en   = 1'b1;
                    rf_addr = AW'(q.b[SLOT_ADR_LO]);
                    if (!q.tx) begin
                        rf_we    = 1'b1;
                        rf_wdata = q.data;
                        d.st     = ST_WB;
                        d.idx    = 2'd0;
                    end else begin
                        d.st = ST_XWAIT;
                    end
                end else begin
                    mem_valid = 1'b1;
                    if (mem_ready) begin
                        if (q.tx) d.data = mem_rdata;
                        d.st  = ST_WB;
                        d.idx = 2'd0;
                    end
                end
            end
            ST_XWAIT: begin
                d.data = rf_rdata;
                d.st   = ST_WB;
                d.idx  = 2'd0;
            end
            ST_WB: begin
                rf_en = 1'b1;
                rf_we = 1'b1;
                case (slot_of(q.rfm, q.idx))
                    SLOT_CNT_HI: rf_wdata = new_cnt[MAW-1:DW];
                    SLOT_CNT_LO: rf_wdata = new_cnt[DW-1:0];
                    SLOT_ADR_HI: rf_wdata = new_adr[MAW-1:DW];
                    default:     rf_wdata = new_adr[DW-1:0];
                endcase
                if (q.idx == last_idx) begin
                    d.st     = ST_DONE;
                    d.ack_rx = !q.tx;
                    d.ack_tx = q.tx;
                    d.eob    = (new_cnt == '0);
                end else begin
                    d.idx = q.idx + 2'd1;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_ack    = q.ack_rx;
    assign tx_ack    = q.ack_tx;
    assign rx_eob    = q.eob && !q.tx;
    assign tx_eob    = q.eob && q.tx;
    assign cfg_err   = q.err;
    assign tx_data   = q.data;
    assign mem_we    = !q.tx;
    assign mem_addr  = adr16;
    assign mem_wdata = q.data;
endmodule

// File: rtl/rfdma_channel_chk.sv
module rfdma_channel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_ack,
    input logic        tx_ack,
    input logic        rx_eob,
    input logic        tx_eob,
    input logic        cfg_err,
    input logic        rf_en,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic [15:0] mem_addr
);
    // R11
    single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ack, tx_ack}));

    // R8
    rx_eob_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eob |-> rx_ack);

    // R8
    tx_eob_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eob |-> tx_ack);

    // R7
    err_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!rx_ack && !tx_ack));

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    // R11
    mem_rf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !rf_en);
endmodule

bind rfdma_channel rfdma_channel_chk u_chk (.*);

// File: tb/rfdma_channel_tb.sv
module rfdma_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        rx_req = 1'b0, tx_req = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ack, tx_ack, rx_eob, tx_eob, cfg_err;
    logic [7:0]  tx_data;
    logic        rf_en, rf_we;
    logic [7:0]  rf_addr, rf_wdata;
    logic [7:0]  rf_rdata = '0;
    logic        mem_valid, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;

    logic [7:0]  rf_m [256];
    logic [7:0]  mem_m [4096];
    int          wcnt = 0;

    int total = 0, bad = 0;
    int err_seen = 0, overlap = 0;
    bit finished = 0;

    typedef struct { bit tx; bit eob; logic [7:0] data; } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    rfdma_channel u_dut (.*);

    // register-file model: one-cycle synchronous read
    always @(posedge clk) begin
        if (rf_en) begin
            if (rf_we) rf_m[rf_addr] <= rf_wdata;
            else       rf_rdata <= rf_m[rf_addr];
        end
    end

    // memory model: 12-bit alias, two wait cycles
    assign mem_rdata = mem_m[mem_addr[11:0]];
    always @(posedge clk)
        if (mem_valid && mem_ready && mem_we) mem_m[mem_addr[11:0]] <= mem_wdata;
    always @(negedge clk) begin
        if (mem_valid) begin
            mem_ready <= (wcnt == 2);
            wcnt      <= wcnt + 1;
        end else begin
            mem_ready <= 1'b0;
            wcnt      <= 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: scoreboard pop on every acknowledge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_err) err_seen++;
            if (mem_valid && rf_en) overlap++;
            if (rx_ack || tx_ack) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected ack", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R10 ack direction", {31'd0, tx_ack}, {31'd0, e.tx});
                    check("R8 eob", {31'd0, (rx_eob | tx_eob)}, {31'd0, e.eob});
                    if (e.tx) check("R3/R5 tx byte", {24'd0, tx_data}, {24'd0, e.data});
                end
            end
        end
    end

    task automatic cfg(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic xfer(input bit tx, input bit eob, input logic [7:0] edata, input logic [7:0] rb);
        exp_t e;
        bit got = 0;
        e.tx = tx; e.eob = eob; e.data = edata;
        exp_q.push_back(e);
        @(negedge clk);
        rx_data = rb;
        if (tx) tx_req = 1'b1; else rx_req = 1'b1;
        for (int i = 0; i < 300 && !got; i++) begin
            @(negedge clk);
            if ((tx && tx_ack) || (!tx && rx_ack)) got = 1;
        end
        rx_req = 1'b0; tx_req = 1'b0;
        check("R3/R5 transfer acknowledged", {31'd0, got}, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic hold_req(input bit tx, input int n,
                            output int acks, output int errs, output int wrs,
                            output int rds, output int mv);
        acks = 0; errs = 0; wrs = 0; rds = 0; mv = 0;
        @(negedge clk);
        if (tx) tx_req = 1'b1; else rx_req = 1'b1;
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            if (i == n) begin rx_req = 1'b0; tx_req = 1'b0; end
            if (rx_ack || tx_ack) acks++;
            if (cfg_err) errs++;
            if (rf_en && rf_we) wrs++;
            if (rf_en) rds++;
            if (mem_valid) mv++;
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int a, e, w, r, m, e0;
        for (int i = 0; i < 256; i++) rf_m[i] = 8'h00;
        for (int i = 0; i < 4096; i++) mem_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 idle outputs", {25'd0, rx_ack, tx_ack, rx_eob, tx_eob, cfg_err, rf_en, mem_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3/R4/R6 register-file receive, address pointer out of range but unused
        rf_m[8'h20] = 8'h40; rf_m[8'h21] = 8'h03; rf_m[8'h43] = 8'h99;
        cfg(2'd0, 8'h21);
        cfg(2'd1, 8'hF0);
        e0 = err_seen;
        xfer(0, 0, 8'h00, 8'hA5);
        check("R3 rx byte stored", {24'd0, rf_m[8'h40]}, 8'hA5);
        check("R6 rf address incremented", {24'd0, rf_m[8'h20]}, 8'h41);
        check("R6 rf count decremented", {24'd0, rf_m[8'h21]}, 8'h02);
        check("R4 no cfg_err from ignored pointer", err_seen - e0, 0);
        xfer(0, 0, 8'h00, 8'h5A);
        xfer(0, 1, 8'h00, 8'h3C);
        check("R8 count reached zero", {24'd0, rf_m[8'h21]}, 8'h00);
        check("R3 third byte stored", {24'd0, rf_m[8'h42]}, 8'h3C);

        // R9 zero count: no response
        hold_req(0, 12, a, e, w, r, m);
        check("R9 no ack on zero count", a, 0);
        check("R9 no rf write on zero count", w, 0);
        check("R9 no memory access", m, 0);
        check("R9 next byte untouched", {24'd0, rf_m[8'h43]}, 8'h99);

        // R5/R6/R2 memory transmit with carry/borrow, address pointer bit0 ignored
        rf_m[8'h30] = 8'h01; rf_m[8'h31] = 8'h00; rf_m[8'h34] = 8'h12; rf_m[8'h35] = 8'hFF;
        mem_m[12'h2FF] = 8'hC3;
        cfg(2'd2, 8'h30);
        cfg(2'd3, 8'h35);
        xfer(1, 0, 8'hC3, 8'h00);
        check("R6 count borrow high", {24'd0, rf_m[8'h30]}, 8'h00);
        check("R6 count borrow low", {24'd0, rf_m[8'h31]}, 8'hFF);
        check("R2 R6 address carry high", {24'd0, rf_m[8'h34]}, 8'h13);
        check("R6 address carry low", {24'd0, rf_m[8'h35]}, 8'h00);

        // R5 memory receive, last byte
        rf_m[8'h50] = 8'h00; rf_m[8'h51] = 8'h01; rf_m[8'h52] = 8'hAB; rf_m[8'h53] = 8'hCD;
        cfg(2'd0, 8'h50);
        cfg(2'd1, 8'h52);
        xfer(0, 1, 8'h00, 8'h77);
        check("R5 memory write", {24'd0, mem_m[12'hBCD]}, 8'h77);
        check("R6 memory-mode address low", {24'd0, rf_m[8'h53]}, 8'hCE);
        check("R6 memory-mode count low", {24'd0, rf_m[8'h51]}, 8'h00);

        // R7 counter pointer out of range
        cfg(2'd2, 8'hE0);
        hold_req(1, 1, a, e, w, r, m);
        check("R7 cfg_err raised (counter)", {31'd0, e > 0}, 1);
        check("R7 no ack", a, 0);
        check("R7 no rf access", r, 0);
        check("R7 no memory access", m, 0);
        // R7 address pointer out of range in memory mode
        cfg(2'd2, 8'h30);
        cfg(2'd3, 8'hE1);
        hold_req(1, 1, a, e, w, r, m);
        check("R7 cfg_err raised (address)", {31'd0, e > 0}, 1);
        check("R7 no rf access (address)", r, 0);
        // R7 boundary pair at DEh, register-file transmit
        rf_m[8'hDE] = 8'h60; rf_m[8'hDF] = 8'h01; rf_m[8'h60] = 8'h5E;
        cfg(2'd2, 8'hDF);
        xfer(1, 1, 8'h5E, 8'h00);
        check("R7 boundary address written back", {24'd0, rf_m[8'hDE]}, 8'h61);

        // R10/R12 simultaneous requests, separate descriptors
        rf_m[8'h70] = 8'h80; rf_m[8'h71] = 8'h02;
        rf_m[8'h74] = 8'h90; rf_m[8'h75] = 8'h02; rf_m[8'h90] = 8'hE7;
        cfg(2'd0, 8'h71);
        cfg(2'd2, 8'h75);
        begin
            exp_t er, et;
            bit grx = 0, gtx = 0;
            er.tx = 0; er.eob = 0; er.data = 8'h00;
            et.tx = 1; et.eob = 0; et.data = 8'hE7;
            exp_q.push_back(er);
            exp_q.push_back(et);
            @(negedge clk);
            rx_data = 8'h11; rx_req = 1'b1; tx_req = 1'b1;
            for (int i = 0; i < 400 && !(grx && gtx); i++) begin
                @(negedge clk);
                if (rx_ack) begin grx = 1; rx_req = 1'b0; end
                if (tx_ack) begin gtx = 1; tx_req = 1'b0; end
            end
            rx_req = 1'b0; tx_req = 1'b0;
            check("R10 both served", {30'd0, grx, gtx}, 3);
        end
        repeat (3) @(negedge clk);
        check("R12 rx descriptor advanced", {24'd0, rf_m[8'h70]}, 8'h81);
        check("R12 tx descriptor advanced", {24'd0, rf_m[8'h74]}, 8'h91);
        check("R12 rx byte stored", {24'd0, rf_m[8'h80]}, 8'h11);
        check("R11 no rf access during memory wait", overlap, 0);
        check("R10 scoreboard drained", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule